// File: doc/BRIEF.md
# Word-Scaled Transmit/Receive FIFO Pair

This block places two first-in first-out queues between a processor-facing data port and a serial shift engine. Both queues share a fixed byte budget (16 bytes each by default). The number of words each queue can hold follows the configured word size: 16 words at 8 bits, 8 words at 16 bits and 4 words at 32 bits. Words are masked to the active width as they enter.

The processor writes outgoing words and reads incoming words. The shift engine pops outgoing words, pushes incoming words, reports whether it is still holding a word, and pulses a frame-error input. A 32-bit status word shows both fill levels, a receive-empty bit and three sticky fault flags: receive overflow, transmit underrun and frame error. A receive and a transmit level interrupt are each chosen by a 2-bit mode field. A fault interrupt combines the sticky flags with per-flag enables. Changing the word size empties both queues.

Top module: `xfer_fifo_pair`

## Requirements
- R1: Capacity follows `cfg_wsize`: 0 gives 16 words of 8 bits, 1 gives 8 words of 16 bits, 2 and 3 give 4 words of 32 bits. Bits above the active width are stored as zero. A processor write to a full transmit queue is dropped.
- R2: Words leave each queue in arrival order. `cpu_rdata` and `sh_tx_data` update one cycle after their pop strobe. Popping an empty queue returns zero and leaves the level unchanged.
- R3: A shift-engine push into a full receive queue discards the word and sets status bit 6. Bit 6 stays set until `clr_flags[1]` is pulsed. If set and clear arrive in the same cycle, set wins.
- R4: A shift-engine pop from an empty transmit queue sets status bit 8, which stays set until `clr_flags[0]` is pulsed.
- R5: A pulse on `sh_frame_err` sets status bit 12, which stays set until `clr_flags[2]` is pulsed.
- R6: Status layout: bits [28:24] hold the receive level, bits [20:16] the transmit level, and bit 5 is 1 while the receive queue is empty. All other bits read zero.
- R7: `rx_irq` follows `irq_mode[1:0]`:
  - 0: the queue is empty.
  - 1: the queue is not empty.
  - 2: 2×level ≥ capacity.
  - 3: level equals capacity.
- R8: `tx_irq` follows `irq_mode[3:2]`:
  - 0: the queue is empty and `sh_busy` is low.
  - 1: the queue is empty.
  - 2: 2×free slots ≥ capacity.
  - 3: at least one slot is free.
- R9: `fault_irq` is the OR of each sticky flag ANDed with its enable. `fault_en[0]` enables underrun, `fault_en[1]` overflow and `fault_en[2]` frame error.
- R10: A change of `cfg_wsize` empties both queues at the next clock edge. A push in that same cycle is ignored.
- R11: Synchronous reset clears both levels, all flags and both data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wsize | input | 2 | Word size select |
| irq_mode | input | 4 | [1:0] receive and [3:2] transmit interrupt condition |
| fault_en | input | 3 | Fault interrupt enables (underrun, overflow, frame) |
| clr_flags | input | 3 | Sticky flag clear strobes, same bit order |
| cpu_wr | input | 1 | Push `cpu_wdata` into transmit queue |
| cpu_wdata | input | 32 | Outgoing word |
| cpu_rd | input | 1 | Pop receive queue |
| cpu_rdata | output | 32 | Received word, registered |
| sh_tx_pop | input | 1 | Shift engine takes a transmit word |
| sh_tx_data | output | 32 | Word taken by the shift engine, registered |
| sh_busy | input | 1 | Shift engine still holds a word |
| sh_rx_push | input | 1 | Shift engine delivers a received word |
| sh_rx_data | input | 32 | Received word from the shift engine |
| sh_frame_err | input | 1 | Frame error pulse |
| status | output | 32 | Levels and flags |
| rx_irq | output | 1 | Receive level interrupt |
| tx_irq | output | 1 | Transmit level interrupt |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The level-bound checks assume that `cfg_wsize` only changes to start a flush, and they are masked in that one cycle. The stimulus therefore alters the word size only deliberately and never mid-sequence. The properties allow strobes to arrive on empty or full queues. The bench applies such strobes on purpose, keeps every input stable between falling edges, and only combines push and word-size change in the dedicated flush test.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  typedef enum logic [1:0] {WS_8 = 2'd0, WS_16 = 2'd1, WS_32 = 2'd2, WS_32B = 2'd3} wsize_e;

  function automatic int unsigned bytes_log2(input logic [1:0] ws);
    case (ws)
      2'd0:    return 0;
      2'd1:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] word_mask(input logic [1:0] ws);
    case (ws)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_lost,
  output logic          pop_lost
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic          do_push, do_pop;

  assign full      = (level >= cap);
  assign empty     = (level == '0);
  assign do_push   = push & ~full & ~flush;
  assign do_pop    = pop & ~empty & ~flush;
  assign push_lost = push & full & ~flush;
  assign pop_lost  = pop & empty & ~flush;

  // pointers wrap at the active capacity, not at the physical depth
  assign wptr_nx = (({1'b0, wptr} + LW'(1)) >= cap) ? '0 : wptr + AW'(1);
  assign rptr_nx = (({1'b0, rptr} + LW'(1)) >= cap) ? '0 : rptr + AW'(1);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (pop) dout <= do_pop ? mem[rptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr_nx;
      if (do_pop)  rptr <= rptr_nx;
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assert_level_cap_R1: assert property (@(posedge clk) disable iff (rst || flush)
    level <= cap);
  assert_full_push_R3: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop && !flush |=> level == $past(level));
  assert_empty_pop_R2: assert property (@(posedge clk) disable iff (rst)
    pop && empty && !flush |=> dout == '0);
endmodule

// File: rtl/level_irq.sv
module level_irq #(
  parameter int LW      = 5,
  parameter bit TX_SIDE = 1'b0
) (
  input  logic [1:0]    mode,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] cap,
  input  logic          sh_busy,
  output logic          irq
);
  generate
    if (TX_SIDE) begin : g_tx
      logic [LW-1:0] free;
      assign free = cap - level;
      always_comb begin
        case (mode)
          2'd0:    irq = (level == '0) && !sh_busy;
          2'd1:    irq = (level == '0);
          2'd2:    irq = ({free, 1'b0} >= {1'b0, cap});
          default: irq = (free != '0);
        endcase
      end
    end else begin : g_rx
      always_comb begin
        case (mode)
          2'd0:    irq = (level == '0);
          2'd1:    irq = (level != '0);
          2'd2:    irq = ({level, 1'b0} >= {1'b0, cap});
          default: irq = (level == cap);
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair #(
  parameter int DEPTH_BYTES = 16,
  parameter int DW          = 32,
  localparam int AW         = $clog2(DEPTH_BYTES),
  localparam int LW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_wsize,
  input  logic [3:0]    irq_mode,
  input  logic [2:0]    fault_en,
  input  logic [2:0]    clr_flags,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  input  logic          sh_tx_pop,
  output logic [DW-1:0] sh_tx_data,
  input  logic          sh_busy,
  input  logic          sh_rx_push,
  input  logic [DW-1:0] sh_rx_data,
  input  logic          sh_frame_err,
  output logic [31:0]   status,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          fault_irq
);
  import xfer_fifo_pkg::*;

  logic [1:0]    wsize_q;
  logic          flush;
  logic [LW-1:0] cap;
  logic [DW-1:0] mask;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_wr_lost, tx_unf, rx_ovf_evt, rx_rd_lost;
  logic          urun_q, ovf_q, ferr_q;

  assign flush = (cfg_wsize != wsize_q);
  assign cap   = LW'(DEPTH_BYTES >> bytes_log2(wsize_q));
  assign mask  = DW'(word_mask(wsize_q));

  always_ff @(posedge clk) begin
    if (rst) wsize_q <= cfg_wsize;
    else     wsize_q <= cfg_wsize;
  end

  word_fifo #(.DW(DW), .DEPTH(DEPTH_BYTES)) u_txq (
    .clk(clk), .rst(rst), .flush(flush), .cap(cap),
    .push(cpu_wr), .din(cpu_wdata & mask), .pop(sh_tx_pop), .dout(sh_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .push_lost(tx_wr_lost), .pop_lost(tx_unf));

  word_fifo #(.DW(DW), .DEPTH(DEPTH_BYTES)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush), .cap(cap),
    .push(sh_rx_push), .din(sh_rx_data & mask), .pop(cpu_rd), .dout(cpu_rdata),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .push_lost(rx_ovf_evt), .pop_lost(rx_rd_lost));

  level_irq #(.LW(LW), .TX_SIDE(1'b0)) u_rx_irq (
    .mode(irq_mode[1:0]), .level(rx_lvl), .cap(cap), .sh_busy(1'b0), .irq(rx_irq));
  level_irq #(.LW(LW), .TX_SIDE(1'b1)) u_tx_irq (
    .mode(irq_mode[3:2]), .level(tx_lvl), .cap(cap), .sh_busy(sh_busy), .irq(tx_irq));

  // sticky fault flags: a new event in the clear cycle keeps the flag set
  always_ff @(posedge clk) begin
    if (rst) begin
      urun_q <= 1'b0;
      ovf_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      urun_q <= tx_unf       | (urun_q & ~clr_flags[0]);
      ovf_q  <= rx_ovf_evt   | (ovf_q  & ~clr_flags[1]);
      ferr_q <= sh_frame_err | (ferr_q & ~clr_flags[2]);
    end
  end

  assign fault_irq = |({ferr_q, ovf_q, urun_q} & fault_en);

  always_comb begin
    status        = '0;
    status[28:24] = 5'(rx_lvl);
    status[20:16] = 5'(tx_lvl);
    status[12]    = ferr_q;
    status[8]     = urun_q;
    status[6]     = ovf_q;
    status[5]     = rx_empty;
  end

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    sh_rx_push && rx_full && !flush |=> status[6]);
  assert_urun_set_R4: assert property (@(posedge clk) disable iff (rst)
    sh_tx_pop && tx_empty && !flush |=> status[8]);
  assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (status[28:24] == 5'd0) && (status[20:16] == 5'd0));
  assert_rx_irq_R7: assert property (@(posedge clk) disable iff (rst)
    rx_irq && irq_mode[1:0] == 2'd0 |-> status[5]);
  assert_tx_irq_R8: assert property (@(posedge clk) disable iff (rst || flush)
    tx_irq && irq_mode[3:2] == 2'd3 |-> !tx_full);
endmodule

// File: tb/test_xfer_fifo_pair.sv
`timescale 1ns/1ps
module test_xfer_fifo_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_wsize = 2'd0;
  logic [3:0]  irq_mode = 4'd0;
  logic [2:0]  fault_en = 3'd0;
  logic [2:0]  clr_flags = 3'd0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata, sh_tx_data, status;
  logic        sh_tx_pop = 1'b0, sh_busy = 1'b0, sh_rx_push = 1'b0, sh_frame_err = 1'b0;
  logic [31:0] sh_rx_data = '0;
  logic        rx_irq, tx_irq, fault_irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  xfer_fifo_pair i_xfer_fifo_pair (
    .clk(clk), .rst(rst), .cfg_wsize(cfg_wsize), .irq_mode(irq_mode),
    .fault_en(fault_en), .clr_flags(clr_flags), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data), .sh_busy(sh_busy),
    .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data), .sh_frame_err(sh_frame_err),
    .status(status), .rx_irq(rx_irq), .tx_irq(tx_irq), .fault_irq(fault_irq));

  // {wsize[1:0], pushes[4:0], rx mode[1:0], expected level[4:0], expected rx_irq}
  localparam logic [14:0] VEC [14] = '{
    {2'd0, 5'd0,  2'd0, 5'd0,  1'b1},
    {2'd0, 5'd1,  2'd1, 5'd1,  1'b1},
    {2'd0, 5'd7,  2'd2, 5'd7,  1'b0},
    {2'd0, 5'd8,  2'd2, 5'd8,  1'b1},
    {2'd0, 5'd16, 2'd3, 5'd16, 1'b1},
    {2'd0, 5'd18, 2'd3, 5'd16, 1'b1},
    {2'd1, 5'd4,  2'd2, 5'd4,  1'b1},
    {2'd1, 5'd3,  2'd2, 5'd3,  1'b0},
    {2'd1, 5'd8,  2'd3, 5'd8,  1'b1},
    {2'd2, 5'd4,  2'd3, 5'd4,  1'b1},
    {2'd2, 5'd6,  2'd3, 5'd4,  1'b1},
    {2'd2, 5'd3,  2'd3, 5'd3,  1'b0},
    {2'd3, 5'd2,  2'd2, 5'd2,  1'b1},
    {2'd2, 5'd0,  2'd1, 5'd0,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] ws, input logic [3:0] md);
    rst = 1'b1; cfg_wsize = ws; irq_mode = md;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    sh_rx_push = 1'b1; sh_rx_data = d;
    @(negedge clk);
    sh_rx_push = 1'b0;
  endtask

  task automatic write_tx(input logic [31:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic read_rx();
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic pop_tx();
    sh_tx_pop = 1'b1;
    @(negedge clk);
    sh_tx_pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R11 / R6 reset state
    do_reset(2'd0, 4'd0);
    check("R11 status", status, 32'h0000_0020);
    check("R11 rdata", cpu_rdata, 32'h0);
    check("R11 txdata", sh_tx_data, 32'h0);
    check("R7 rx_irq mode0 empty", {31'h0, rx_irq}, 32'h1);
    check("R8 tx_irq mode0 idle", {31'h0, tx_irq}, 32'h1);
    check("R9 fault idle", {31'h0, fault_irq}, 32'h0);

    // vector table: R1 capacity, R7 rx interrupt modes, R3 overflow
    foreach (VEC[k]) begin
      do_reset(VEC[k][14:13], {2'b00, VEC[k][7:6]});
      for (int i = 0; i < int'(VEC[k][12:8]); i++) push_rx(32'h100 + i);
      check("R1 rx level", {27'h0, status[28:24]}, {27'h0, VEC[k][5:1]});
      check("R7 rx_irq", {31'h0, rx_irq}, {31'h0, VEC[k][0]});
      check("R3 overflow flag", {31'h0, status[6]},
            {31'h0, (VEC[k][12:8] > VEC[k][5:1])});
    end

    // R2 ordering, R1 masking, empty read returns zero
    do_reset(2'd1, 4'd0);
    push_rx(32'hAAAA_1234);
    push_rx(32'hBBBB_5678);
    read_rx();
    check("R2 first word masked R1", cpu_rdata, 32'h0000_1234);
    read_rx();
    check("R2 second word", cpu_rdata, 32'h0000_5678);
    read_rx();
    check("R2 empty read zero", cpu_rdata, 32'h0);
    check("R2 empty read level", status, 32'h0000_0020);

    // R1 tx full drop, R8 tx modes, R4 underrun, R9 enables
    do_reset(2'd2, 4'b1100);
    for (int i = 1; i <= 6; i++) write_tx(32'hC000_0000 + i);
    check("R1 tx level capped", {27'h0, status[20:16]}, 32'd4);
    check("R8 mode3 full", {31'h0, tx_irq}, 32'h0);
    pop_tx();
    check("R2 tx first", sh_tx_data, 32'hC000_0001);
    check("R8 mode3 one free", {31'h0, tx_irq}, 32'h1);
    irq_mode = 4'b1000;
    @(negedge clk);
    check("R8 mode2 one free", {31'h0, tx_irq}, 32'h0);
    pop_tx();
    check("R2 tx second", sh_tx_data, 32'hC000_0002);
    check("R8 mode2 half free", {31'h0, tx_irq}, 32'h1);
    pop_tx();
    pop_tx();
    check("R1 tx dropped words absent", sh_tx_data, 32'hC000_0004);
    irq_mode = 4'b0100;
    @(negedge clk);
    check("R8 mode1 empty", {31'h0, tx_irq}, 32'h1);
    irq_mode = 4'b0000; sh_busy = 1'b1;
    @(negedge clk);
    check("R8 mode0 busy", {31'h0, tx_irq}, 32'h0);
    sh_busy = 1'b0;
    @(negedge clk);
    check("R8 mode0 idle", {31'h0, tx_irq}, 32'h1);
    pop_tx();
    check("R4 underrun set", {31'h0, status[8]}, 32'h1);
    check("R2 underrun data zero", sh_tx_data, 32'h0);
    check("R9 masked", {31'h0, fault_irq}, 32'h0);
    fault_en = 3'b001;
    @(negedge clk);
    check("R9 underrun enabled", {31'h0, fault_irq}, 32'h1);
    check("R4 sticky", {31'h0, status[8]}, 32'h1);
    clr_flags = 3'b001;
    @(negedge clk);
    clr_flags = 3'b000;
    check("R4 cleared", {31'h0, status[8]}, 32'h0);
    check("R9 after clear", {31'h0, fault_irq}, 32'h0);

    // R5 frame error
    fault_en = 3'b100;
    sh_frame_err = 1'b1;
    @(negedge clk);
    sh_frame_err = 1'b0;
    @(negedge clk);
    check("R5 frame sticky", {31'h0, status[12]}, 32'h1);
    check("R9 frame enabled", {31'h0, fault_irq}, 32'h1);
    clr_flags = 3'b100;
    @(negedge clk);
    clr_flags = 3'b000;
    check("R5 frame cleared", {31'h0, status[12]}, 32'h0);
    fault_en = 3'b000;

    // R3 overflow sticky through reads, then cleared
    do_reset(2'd2, 4'd0);
    for (int i = 0; i < 5; i++) push_rx(32'h55 + i);
    read_rx();
    check("R3 overflow kept", {31'h0, status[6]}, 32'h1);
    check("R3 discarded word not stored", cpu_rdata, 32'h55);
    fault_en = 3'b010;
    @(negedge clk);
    check("R9 overflow enabled", {31'h0, fault_irq}, 32'h1);
    clr_flags = 3'b010;
    @(negedge clk);
    clr_flags = 3'b000;
    check("R3 overflow cleared", {31'h0, status[6]}, 32'h0);
    fault_en = 3'b000;

    // R10 word size change flushes both queues, concurrent push ignored
    do_reset(2'd0, 4'd0);
    for (int i = 0; i < 3; i++) push_rx(32'h11 + i);
    write_tx(32'h77);
    write_tx(32'h78);
    cfg_wsize = 2'd1;
    sh_rx_push = 1'b1; sh_rx_data = 32'h99;
    @(negedge clk);
    sh_rx_push = 1'b0;
    check("R10 flushed", status, 32'h0000_0020);
    read_rx();
    check("R10 empty after flush", cpu_rdata, 32'h0);

    finish_run();
  end
endmodule